// File: doc/BRIEF.md
# Channel Order-Out Command Sequencer

This block steps a simple I/O channel through the order-out service cycle. When started with a command address, it fetches the even word of the command doubleword from memory. It takes the order byte from that word and classifies the order. A transfer-in-channel (jump) order reloads the command address and the fetch starts again at the new address. Any other order loads the byte address and the transfer direction. The block then fetches the odd word, loads the byte count, and pulses a request-strobe acknowledge so that the device controller can take the order.

Memory is a request/acknowledge port with a parity-error flag. A parity error on any fetch sets a sticky memory-error bit. Two jump orders in a row set a control-error bit. Either error sets the halt bit. A halt stops further command re-fetch and stops the byte count from loading. All status is held until the next start.

States: `ST_IDLE` (waiting for start), `ST_FETCH_EVEN` (even word request), `ST_DECODE` (classify the order, load addresses, decide), `ST_FETCH_ODD` (odd word request), `ST_HANDOFF` (acknowledge pulse). Transitions: IDLE→FETCH_EVEN on start; FETCH_EVEN→DECODE on acknowledge; DECODE→FETCH_EVEN on a jump with no halt, otherwise DECODE→FETCH_ODD; FETCH_ODD→HANDOFF on acknowledge; HANDOFF→IDLE always.

Top module: `chan_order_out_seq`

## Requirements
- R1: After synchronous reset the block is idle. `busy`, `mem_req` and `dc_rsa` are low, and all address, count, order and status outputs are zero.
- R2: A `start` seen in IDLE loads `cmd_addr` from `start_cmd_addr` and requests the even word at `mem_addr = {cmd_addr, 1'b0}`. A `start` while busy has no effect.
- R3: The order byte is command-word bits 31:24. It is a jump when `(order & JMP_MASK) == JMP_CODE`, by default low nibble 4'h8. It is read-backward when `(order & BKWD_MASK) == BKWD_CODE` and it is not a jump, by default low nibble 4'hC. `order_out` shows the last decoded order byte.
- R4: For a non-jump order, `byte_addr` takes word bits 18:2 as its upper bits. Its two low bits are 2'b11 for a read-backward order and word bits 1:0 otherwise. `backward` shows the read-backward decision and is cleared at start.
- R5: For a jump order, `cmd_addr` takes word bits 18:3. If no halt condition exists, the even word at the new address is fetched next.
- R6: A jump that directly follows a jump sets `st_ctl_err`. No further even fetch happens; the block goes on to the odd fetch.
- R7: A parity error reported with any fetch acknowledge sets `st_mem_err`.
- R8: `st_halt` is set whenever `st_mem_err` or `st_ctl_err` is set by the end of the cycle. A halt raised at a jump blocks the re-fetch.
- R9: `byte_cnt` takes odd-word bits 15:0 only when no halt, no memory error, and no parity error on that fetch exist. Otherwise it keeps its previous value.
- R10: Each accepted start ends with exactly one single-cycle `dc_rsa` pulse after the odd fetch, and `busy` falls on the next cycle.
- R11: Accepting a start clears all three status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an order-out cycle |
| start_cmd_addr | input | 16 | Initial command doubleword address |
| busy | output | 1 | Cycle in progress |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | 17 | Word address: command address and odd-word bit |
| mem_ack | input | 1 | Memory data valid for one cycle |
| mem_rdata | input | 32 | Memory read word |
| mem_perr | input | 1 | Parity error, qualified by mem_ack |
| order_out | output | 8 | Order byte offered to the device controller |
| dc_rsa | output | 1 | Request-strobe acknowledge pulse |
| cmd_addr | output | 16 | Command address counter |
| byte_addr | output | 19 | Byte address |
| byte_cnt | output | 16 | Byte count |
| backward | output | 1 | Read-backward flag |
| st_mem_err | output | 1 | Memory-error status |
| st_ctl_err | output | 1 | Control-error status |
| st_halt | output | 1 | Halt status |

## Verification
The bench builds the block with its default parameters: a 19-bit byte address, a 16-bit count, a 32-bit word, and the low-nibble codes 4'h8 for jump and 4'hC for read-backward. Its memory model holds 256 words and decodes only the low eight bits of the word address. This lets random jump targets land on previously written commands, so single jumps, double jumps and jump-after-jump halts happen often. A random acknowledge delay of zero to two cycles is applied. Parity errors are injected on about one fetch in twelve, with directed cases for an error on the even word, on the odd word and on a jump word.

// File: rtl/coos_pkg.sv
package coos_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_EVEN,
        ST_DECODE,
        ST_FETCH_ODD,
        ST_HANDOFF
    } coos_state_e;

    typedef struct packed {
        logic is_jump;
        logic is_bkwd;
    } order_class_t;
endpackage

// File: rtl/coos_order_decode.sv
module coos_order_decode
    import coos_pkg::*;
#(
    parameter int ORD_W = 8,
    parameter logic [ORD_W-1:0] JMP_MASK  = 8'h0F,
    parameter logic [ORD_W-1:0] JMP_CODE  = 8'h08,
    parameter logic [ORD_W-1:0] BKWD_MASK = 8'h0F,
    parameter logic [ORD_W-1:0] BKWD_CODE = 8'h0C
) (
    input  logic [ORD_W-1:0] order,
    output order_class_t     cls
);
    logic jmp_hit;
    logic bkwd_hit;

    always_comb begin
        jmp_hit     = ((order & JMP_MASK) == JMP_CODE);
        bkwd_hit    = ((order & BKWD_MASK) == BKWD_CODE);
        // jump takes priority if the two patterns ever overlap (R3)
        cls.is_jump = jmp_hit;
        cls.is_bkwd = bkwd_hit && !jmp_hit;
    end
endmodule

// File: rtl/coos_status_unit.sv
module coos_status_unit (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fetch_ack,
    input  logic perr,
    input  logic dec_en,
    input  logic dec_jump,
    input  logic odd_done,
    input  logic handoff,
    output logic halt_next,
    output logic cnt_ok,
    output logic st_mem_err,
    output logic st_ctl_err,
    output logic st_halt
);
    logic jump_seen;
    logic ctl_next;

    always_comb begin
        ctl_next  = st_ctl_err | (dec_en & dec_jump & jump_seen);
        halt_next = st_mem_err | ctl_next;
        cnt_ok    = odd_done & ~(st_halt | st_mem_err | perr);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_mem_err <= 1'b0;
            st_ctl_err <= 1'b0;
            st_halt    <= 1'b0;
            jump_seen  <= 1'b0;
        end else begin
            if (fetch_ack && perr) st_mem_err <= 1'b1;
            if (dec_en) begin
                st_ctl_err <= ctl_next;
                st_halt    <= st_halt | halt_next;
                if (dec_jump) jump_seen <= 1'b1;
            end
            if (odd_done) jump_seen <= 1'b0;
            if (handoff)  st_halt <= st_halt | st_mem_err;
        end
    end

    assert_halt_cause_R8: assert property (@(posedge clk) disable iff (rst)
        st_halt |-> (st_mem_err || st_ctl_err));

    assert_ctl_needs_jump_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_ctl_err) |-> $past(dec_en && dec_jump));
endmodule

// File: rtl/coos_addr_unit.sv
module coos_addr_unit
    import coos_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ORD_W  = 8,
    parameter int BA_W   = 19,
    parameter int BC_W   = 16,
    parameter int LOW_W  = 2,
    localparam int DW_SH = 3,
    localparam int CA_W  = BA_W - DW_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_load,
    input  logic [CA_W-1:0]   start_ca,
    input  logic              dec_en,
    input  logic [WORD_W-1:0] dec_word,
    input  order_class_t      cls,
    input  logic              cnt_load,
    input  logic [WORD_W-1:0] odd_word,
    output logic [CA_W-1:0]   cmd_addr,
    output logic [BA_W-1:0]   byte_addr,
    output logic [BC_W-1:0]   byte_cnt,
    output logic              backward,
    output logic [ORD_W-1:0]  order_out
);
    logic [BA_W-1:0]  fld;
    logic [LOW_W-1:0] low_bits;

    assign fld = dec_word[BA_W-1:0];

    // backward forces each low byte-address bit high (R4)
    for (genvar gi = 0; gi < LOW_W; gi++) begin : g_low
        assign low_bits[gi] = fld[gi] | cls.is_bkwd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_addr  <= '0;
            byte_addr <= '0;
            byte_cnt  <= '0;
            backward  <= 1'b0;
            order_out <= '0;
        end else begin
            if (start_load) begin
                cmd_addr <= start_ca;
                backward <= 1'b0;
            end
            if (dec_en) begin
                order_out <= dec_word[WORD_W-1 -: ORD_W];
                backward  <= cls.is_bkwd;
                if (cls.is_jump) cmd_addr <= fld[BA_W-1:DW_SH];
                else             byte_addr <= {fld[BA_W-1:LOW_W], low_bits};
            end
            if (cnt_load) byte_cnt <= odd_word[BC_W-1:0];
        end
    end
endmodule

// File: rtl/chan_order_out_seq.sv
module chan_order_out_seq
    import coos_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ORD_W  = 8,
    parameter int BA_W   = 19,
    parameter int BC_W   = 16,
    parameter logic [ORD_W-1:0] JMP_MASK  = 8'h0F,
    parameter logic [ORD_W-1:0] JMP_CODE  = 8'h08,
    parameter logic [ORD_W-1:0] BKWD_MASK = 8'h0F,
    parameter logic [ORD_W-1:0] BKWD_CODE = 8'h0C,
    localparam int CA_W = BA_W - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CA_W-1:0]   start_cmd_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [CA_W:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_perr,
    output logic [ORD_W-1:0]  order_out,
    output logic              dc_rsa,
    output logic [CA_W-1:0]   cmd_addr,
    output logic [BA_W-1:0]   byte_addr,
    output logic [BC_W-1:0]   byte_cnt,
    output logic              backward,
    output logic              st_mem_err,
    output logic              st_ctl_err,
    output logic              st_halt
);
    coos_state_e       st_q, st_d;
    logic [WORD_W-1:0] cmd_word;
    order_class_t      cls;
    logic              start_load, fetch_ack, dec_en, odd_done, handoff;
    logic              halt_next, cnt_ok;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (start)   st_d = ST_FETCH_EVEN;
            ST_FETCH_EVEN: if (mem_ack) st_d = ST_DECODE;
            ST_DECODE:     st_d = (cls.is_jump && !halt_next) ? ST_FETCH_EVEN : ST_FETCH_ODD;
            ST_FETCH_ODD:  if (mem_ack) st_d = ST_HANDOFF;
            ST_HANDOFF:    st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        busy       = (st_q != ST_IDLE);
        mem_req    = (st_q == ST_FETCH_EVEN) || (st_q == ST_FETCH_ODD);
        mem_addr   = {cmd_addr, st_q == ST_FETCH_ODD};
        dc_rsa     = (st_q == ST_HANDOFF);
        start_load = (st_q == ST_IDLE) && start;
        fetch_ack  = mem_req && mem_ack;
        dec_en     = (st_q == ST_DECODE);
        odd_done   = (st_q == ST_FETCH_ODD) && mem_ack;
        handoff    = dc_rsa;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_word <= '0;
        else if ((st_q == ST_FETCH_EVEN) && mem_ack) cmd_word <= mem_rdata;
    end

    coos_order_decode #(
        .ORD_W(ORD_W), .JMP_MASK(JMP_MASK), .JMP_CODE(JMP_CODE),
        .BKWD_MASK(BKWD_MASK), .BKWD_CODE(BKWD_CODE)
    ) u_dec (
        .order (cmd_word[WORD_W-1 -: ORD_W]),
        .cls   (cls)
    );

    coos_status_unit u_stat (
        .clk, .rst,
        .clr       (start_load),
        .fetch_ack (fetch_ack),
        .perr      (mem_perr),
        .dec_en    (dec_en),
        .dec_jump  (cls.is_jump),
        .odd_done  (odd_done),
        .handoff   (handoff),
        .halt_next (halt_next),
        .cnt_ok    (cnt_ok),
        .st_mem_err, .st_ctl_err, .st_halt
    );

    coos_addr_unit #(
        .WORD_W(WORD_W), .ORD_W(ORD_W), .BA_W(BA_W), .BC_W(BC_W)
    ) u_addr (
        .clk, .rst,
        .start_load (start_load),
        .start_ca   (start_cmd_addr),
        .dec_en     (dec_en),
        .dec_word   (cmd_word),
        .cls        (cls),
        .cnt_load   (cnt_ok),
        .odd_word   (mem_rdata),
        .cmd_addr, .byte_addr, .byte_cnt, .backward, .order_out
    );

    assert_rsa_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        dc_rsa |=> (!dc_rsa && !busy));

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_no_even_after_ctl_R6: assert property (@(posedge clk) disable iff (rst)
        (st_ctl_err && mem_req) |-> mem_addr[0]);

    assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        st_mem_err |=> $stable(byte_cnt));

    assert_start_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (!st_mem_err && !st_ctl_err && !st_halt && busy));
endmodule

// File: tb/chan_order_out_seq_tb.sv
module chan_order_out_seq_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [15:0] start_cmd_addr = '0;
    logic        busy, mem_req, mem_ack = 0, mem_perr = 0, dc_rsa;
    logic [16:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  order_out;
    logic [15:0] cmd_addr, byte_cnt;
    logic [18:0] byte_addr;
    logic        backward, st_mem_err, st_ctl_err, st_halt;

    int n_chk = 0, n_bad = 0;
    int fetch_cnt = 0, rsa_cnt = 0, wait_cnt = 0;

    logic [31:0] mem_w [256];
    bit          mem_pe [256];

    // expected state
    logic [15:0] e_ca, e_bc;
    logic [18:0] e_ba;
    logic [7:0]  e_ord;
    bit          e_bk, e_me, e_ce, e_h;
    int          e_fetch;

    always #2.5 clk = ~clk;

    chan_order_out_seq dut_i (
        .clk, .rst, .start, .start_cmd_addr, .busy, .mem_req, .mem_addr,
        .mem_ack, .mem_rdata, .mem_perr, .order_out, .dc_rsa, .cmd_addr,
        .byte_addr, .byte_cnt, .backward, .st_mem_err, .st_ctl_err, .st_halt
    );

    // memory responder and pulse monitor
    always @(negedge clk) begin
        if (dc_rsa) rsa_cnt++;
        if (rst) begin
            mem_ack = 0;
        end else if (mem_ack) begin
            mem_ack = 0; mem_perr = 0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack   = 1;
                mem_rdata = mem_w[mem_addr[7:0]];
                mem_perr  = mem_pe[mem_addr[7:0]];
                fetch_cnt++;
                wait_cnt  = $urandom % 3;
            end else wait_cnt--;
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_jmp(logic [7:0] o); return o[3:0] == 4'h8; endfunction
    function automatic bit is_bk(logic [7:0] o);  return o[3:0] == 4'hC; endfunction

    // reference model of one order-out cycle
    task automatic model(logic [15:0] sa);
        bit js = 0;
        logic [31:0] w;
        e_ca = sa; e_me = 0; e_ce = 0; e_h = 0; e_bk = 0; e_fetch = 0;
        forever begin
            w = mem_w[{e_ca[6:0], 1'b0}];
            e_fetch++;
            if (mem_pe[{e_ca[6:0], 1'b0}]) e_me = 1;
            e_ord = w[31:24];
            e_bk  = is_bk(e_ord);
            if (is_jmp(e_ord)) begin
                if (js) e_ce = 1;
                js = 1;
                e_ca = w[18:3];
            end else begin
                e_ba = {w[18:2], w[1:0] | {2{e_bk}}};
            end
            e_h = e_me | e_ce;
            if (!(is_jmp(e_ord) && !e_h)) break;
        end
        e_fetch++;
        if (!(e_h || e_me || mem_pe[{e_ca[6:0], 1'b1}]))
            e_bc = mem_w[{e_ca[6:0], 1'b1}][15:0];
        if (mem_pe[{e_ca[6:0], 1'b1}]) e_me = 1;
        e_h = e_h | e_me;
    endtask

    task automatic put(logic [6:0] ca, logic [31:0] ev, logic [31:0] od, bit pe_e, bit pe_o);
        mem_w[{ca, 1'b0}] = ev; mem_pe[{ca, 1'b0}] = pe_e;
        mem_w[{ca, 1'b1}] = od; mem_pe[{ca, 1'b1}] = pe_o;
    endtask

    function automatic logic [31:0] cw(logic [7:0] ord, logic [18:0] a);
        return {ord, 5'd0, a};
    endfunction

    task automatic run(logic [15:0] sa, bit poke_busy);
        int t = 0;
        model(sa);
        fetch_cnt = 0; rsa_cnt = 0;
        @(negedge clk); start = 1; start_cmd_addr = sa;
        @(negedge clk); start = 0;
        if (poke_busy) begin
            start = 1; start_cmd_addr = sa ^ 16'h0055;   // must be ignored (R2)
            @(negedge clk); start = 0;
        end
        while (busy && t < 300) begin @(negedge clk); t++; end
        check("R10", "busy_end", busy, 0);
        check("R10", "rsa_pulses", rsa_cnt, 1);
        check("R2", "fetches", fetch_cnt, e_fetch);
        check("R5", "cmd_addr", cmd_addr, e_ca);
        check("R4", "byte_addr", byte_addr, e_ba);
        check("R4", "backward", backward, e_bk);
        check("R3", "order_out", order_out, e_ord);
        check("R9", "byte_cnt", byte_cnt, e_bc);
        check("R7", "st_mem_err", st_mem_err, e_me);
        check("R6", "st_ctl_err", st_ctl_err, e_ce);
        check("R8", "st_halt", st_halt, e_h);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 256; i++) begin mem_w[i] = 32'h0; mem_pe[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "mem_req", mem_req, 0);
        check("R1", "dc_rsa", dc_rsa, 0);
        check("R1", "byte_addr", byte_addr, 0);
        check("R1", "byte_cnt", byte_cnt, 0);
        check("R1", "cmd_addr", cmd_addr, 0);
        check("R1", "order_out", order_out, 0);
        check("R1", "status", {st_mem_err, st_ctl_err, st_halt, backward}, 0);
        e_ba = 0; e_bc = 0;

        // directed: forward read (R4)
        put(7'd1, cw(8'h02, 19'h1234D), 32'h0000_0040, 0, 0);  run(16'd1, 0);
        // backward read, low bits forced (R4)
        put(7'd2, cw(8'h0C, 19'h05550), 32'h0000_0100, 0, 0);  run(16'd2, 0);
        // single jump then order (R5)
        put(7'd3, cw(8'h08, 19'd5 << 3), 32'h0, 0, 0);
        put(7'd5, cw(8'h01, 19'h00A01), 32'h0000_0033, 0, 0);   run(16'd3, 0);
        // jump to jump: control error (R6)
        put(7'd6, cw(8'h18, 19'd7 << 3), 32'h0, 0, 0);
        put(7'd7, cw(8'h28, 19'd9 << 3), 32'h0000_7777, 0, 0);  run(16'd6, 0);
        // parity on even word (R7)
        put(7'd10, cw(8'h02, 19'h00300), 32'h0000_0999, 1, 0); run(16'd10, 0);
        // parity on odd word: count held (R9), clear on new start (R11)
        put(7'd11, cw(8'h03, 19'h00404), 32'h0000_0abc, 0, 1); run(16'd11, 0);
        // parity on jump word: halt blocks re-fetch (R8)
        put(7'd12, cw(8'h08, 19'd1 << 3), 32'h0000_0555, 1, 0); run(16'd12, 0);
        // start while busy ignored (R2)
        run(16'd1, 1);

        // constrained random
        for (int r = 0; r < 400; r++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0] o;
                int sel = $urandom % 20;
                o = $urandom;
                if (sel < 5)       o[3:0] = 4'h8;
                else if (sel < 9)  o[3:0] = 4'hC;
                else               o[3:0] = 4'h1 + ($urandom % 4);
                mem_w[i]  = (i % 2 == 0) ? {o, 5'($urandom), 19'($urandom)} : $urandom;
                mem_pe[i] = ($urandom % 12) == 0;
            end
            run(16'($urandom), ($urandom % 8) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule